// File: doc/BRIEF.md
# Predicated Vector Reduction Sequencer

This block folds a vector of integer elements into one value using a selected associative operation: wrapping add, low-half multiply, signed minimum, signed maximum or bitwise OR. A single `start` pulse captures the element count, the predicate mask, the operation code and the condition options. The unit then steps through the element indices one per cycle. It fetches only the elements whose predicate bit is set, through a combinational register-file read port. It produces exactly the value that a plain left-to-right fold over those elements would give.

The folded value is written once, through the write port, into the lowest-numbered active element. No other element is ever written, so masked-out destination slots keep their old contents. When condition recording is enabled, a 4-bit condition field is derived after every fold step. These fields are merged into one output, either as "any step met it" (bitwise OR) or as "every step met it" (bitwise AND). Operation codes outside the permitted set raise a one-cycle illegal flag and touch nothing.

Top module: `mask_reduce_unit`

## Requirements
- R1: After reset, `busy`, `done`, `illegal`, `rdEn` and `wrEn` are low, and `result` and `crOut` are zero.
- R2: `opSel` selects the fold operation: 0 wrapping add, 1 multiply (low DATA_W bits), 2 signed minimum, 3 signed maximum, 4 bitwise OR. `result` equals the in-order left fold of the active elements, starting from the lowest index.
- R3: Element i is active only when `predMask[i]` is set and i < `vecLen`; a `vecLen` above MAX_VL counts as MAX_VL. Inactive elements are neither read nor written.
- R4: When at least one element is active, exactly one write occurs. It goes to the lowest active index, carries the final `result`, and happens in the cycle where `done` is high.
- R5: With exactly one active element, that element's value is copied back unchanged. With no active element (including `vecLen` = 0), `done` still pulses, nothing is written and `result` is 0.
- R6: The condition field is {lt, gt, eq, so} on bits 3..0. lt, gt and eq come from a signed comparison of a fold-step result with zero, and so is always 0.
- R7: With `crAll` = 0, the per-step fields are merged by bitwise OR. With `crAll` = 1, they are merged by bitwise AND.
- R8: With `rcEn` = 0, or with fewer than two active elements (no fold step), `crOut` is 0.
- R9: `opSel` values 5, 6 and 7 are rejected. `illegal` pulses for one cycle, no read or write occurs, `done` stays low, and the unit is idle again in the following cycle.
- R10: A `start` pulse that arrives while `busy` is high is ignored.
- R11: `done` is a single-cycle pulse. `result` and `crOut` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a reduction (accepted only when idle) |
| vecLen | input | LEN_W | Number of elements, 0 to MAX_VL |
| predMask | input | MAX_VL | Predicate, bit i enables element i |
| opSel | input | 3 | Fold operation code |
| rcEn | input | 1 | Enable condition field recording |
| crAll | input | 1 | 0: OR-merge condition fields, 1: AND-merge |
| rdEn | output | 1 | Read port enable |
| rdAddr | output | IDX_W | Read port element index |
| rdData | input | DATA_W | Read port data, same cycle as `rdAddr` |
| wrEn | output | 1 | Write port enable |
| wrAddr | output | IDX_W | Write port element index |
| wrData | output | DATA_W | Write port data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle rejected-operation pulse |
| result | output | DATA_W | Folded value |
| crOut | output | 4 | Merged condition field {lt,gt,eq,so} |

## Verification
The hardest situation to reach from the ports is a second `start` that arrives in the middle of a scan carrying a different operation and mask. If that pulse were honoured, it would corrupt the latched configuration without any visible handshake. The bench launches a full-length add and, a few cycles later, pulses `start` with an OR over a different mask. It then checks that the result, the destination and the untouched elements all match the original add. The AND/OR condition merging is driven by vectors whose partial sums cross zero, so that the per-step fields actually differ.

// File: rtl/mask_reduce_pkg.sv
package mask_reduce_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_MUL = 3'd1,
    OP_MIN = 3'd2,
    OP_MAX = 3'd3,
    OP_OR  = 3'd4
  } redOp_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;  // latch configuration, zero accumulator
    logic take;   // first active element seeds the accumulator
    logic step;   // fold another active element
  } dpStrobe_t;

  function automatic logic opLegal(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

endpackage

// File: rtl/mask_reduce_dp.sv
module mask_reduce_dp
  import mask_reduce_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [2:0]        opSel,
  input  logic              rcEn,
  input  logic              crAll,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] acc,
  output logic [3:0]        crOut,
  output logic [IDX_W-1:0]  dstIdx
);

  logic [2:0]        opQ;
  logic              rcQ, allQ, steppedQ;
  logic [DATA_W-1:0] accQ, foldVal;
  logic [3:0]        crAccQ, stepCr, mergedCr;

  always_comb begin
    unique case (opQ)
      OP_MUL:  foldVal = accQ * rdData;
      OP_MIN:  foldVal = ($signed(rdData) < $signed(accQ)) ? rdData : accQ;
      OP_MAX:  foldVal = ($signed(rdData) > $signed(accQ)) ? rdData : accQ;
      OP_OR:   foldVal = accQ | rdData;
      default: foldVal = accQ + rdData;
    endcase
  end

  // {lt, gt, eq, so}
  always_comb begin
    stepCr[3] = foldVal[DATA_W-1];
    stepCr[2] = !foldVal[DATA_W-1] && (foldVal != '0);
    stepCr[1] = (foldVal == '0);
    stepCr[0] = 1'b0;
    if (!steppedQ)  mergedCr = stepCr;
    else if (allQ)  mergedCr = crAccQ & stepCr;
    else            mergedCr = crAccQ | stepCr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ      <= '0;
      rcQ      <= 1'b0;
      allQ     <= 1'b0;
      steppedQ <= 1'b0;
      accQ     <= '0;
      crAccQ   <= '0;
      dstIdx   <= '0;
    end else if (strobe.clear) begin
      opQ      <= opSel;
      rcQ      <= rcEn;
      allQ     <= crAll;
      steppedQ <= 1'b0;
      accQ     <= '0;
      crAccQ   <= '0;
      dstIdx   <= '0;
    end else if (strobe.take) begin
      accQ   <= rdData;
      dstIdx <= idx;
    end else if (strobe.step) begin
      accQ     <= foldVal;
      crAccQ   <= mergedCr;
      steppedQ <= 1'b1;
    end
  end

  assign acc   = accQ;
  assign crOut = (rcQ && steppedQ) ? crAccQ : 4'h0;

endmodule

// File: rtl/mask_reduce_ctrl.sv
module mask_reduce_ctrl
  import mask_reduce_pkg::*;
#(
  parameter int MAX_VL = 16,
  parameter int IDX_W  = 4,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  vecLen,
  input  logic [MAX_VL-1:0] predMask,
  input  logic [2:0]        opSel,
  output dpStrobe_t         strobe,
  output logic [IDX_W-1:0]  idx,
  output logic              rdEn,
  output logic              wrEn,
  output logic              busy,
  output logic              done,
  output logic              illegal
);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FIN, ST_BAD} seqState_e;

  seqState_e         stateQ;
  logic [IDX_W-1:0]  idxQ, lastQ;
  logic [MAX_VL-1:0] maskQ;
  logic              seenQ, active, accept;
  logic [LEN_W-1:0]  clampLen;

  assign clampLen = (vecLen > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : vecLen;
  assign accept   = (stateQ == ST_IDLE) && start;
  assign active   = (stateQ == ST_SCAN) && maskQ[idxQ];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
      lastQ  <= '0;
      maskQ  <= '0;
      seenQ  <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: if (start) begin
          idxQ  <= '0;
          seenQ <= 1'b0;
          maskQ <= predMask;
          lastQ <= IDX_W'(clampLen - LEN_W'(1));
          if (!opLegal(opSel))        stateQ <= ST_BAD;
          else if (clampLen == '0)    stateQ <= ST_FIN;
          else                        stateQ <= ST_SCAN;
        end
        ST_SCAN: begin
          seenQ <= seenQ | active;
          if (idxQ == lastQ) stateQ <= ST_FIN;
          else               idxQ   <= idxQ + IDX_W'(1);
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clear = accept && opLegal(opSel);
    strobe.take  = active && !seenQ;
    strobe.step  = active && seenQ;
  end

  assign idx     = idxQ;
  assign rdEn    = active;
  assign wrEn    = (stateQ == ST_FIN) && seenQ;
  assign done    = (stateQ == ST_FIN);
  assign illegal = (stateQ == ST_BAD);
  assign busy    = (stateQ != ST_IDLE);

endmodule

// File: rtl/mask_reduce_unit.sv
module mask_reduce_unit
  import mask_reduce_pkg::*;
#(
  parameter int MAX_VL = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
  localparam int LEN_W = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  vecLen,
  input  logic [MAX_VL-1:0] predMask,
  input  logic [2:0]        opSel,
  input  logic              rcEn,
  input  logic              crAll,
  output logic              rdEn,
  output logic [IDX_W-1:0]  rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        crOut
);

  dpStrobe_t strobe;

  mask_reduce_ctrl #(.MAX_VL(MAX_VL), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen),
    .predMask(predMask), .opSel(opSel), .strobe(strobe), .idx(rdAddr),
    .rdEn(rdEn), .wrEn(wrEn), .busy(busy), .done(done), .illegal(illegal)
  );

  mask_reduce_dp #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opSel(opSel), .rcEn(rcEn),
    .crAll(crAll), .idx(rdAddr), .rdData(rdData), .acc(result),
    .crOut(crOut), .dstIdx(wrAddr)
  );

  assign wrData = result;

endmodule

// File: rtl/mask_reduce_chk.sv
module mask_reduce_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       illegal,
  input logic       rdEn,
  input logic       wrEn,
  input logic [3:0] crOut
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!wrEn && !rdEn && !done)); // R9

  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    illegal |=> !busy); // R9

  AST_WRITE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> done); // R4

  AST_SO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !crOut[0]); // R6

  AST_READ_IN_SCAN: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> busy); // R3

  AST_CR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(crOut)); // R11

endmodule

bind mask_reduce_unit mask_reduce_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .illegal(illegal), .rdEn(rdEn), .wrEn(wrEn), .crOut(crOut)
);

// File: tb/mask_reduce_unit_test.sv
`timescale 1ns/1ps
module mask_reduce_unit_test;
  localparam int MAX_VL = 16;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;
  localparam int LEN_W  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] vecLen = '0;
  logic [MAX_VL-1:0] predMask = '0;
  logic [2:0] opSel = '0;
  logic rcEn = 1'b0, crAll = 1'b0;
  logic rdEn, wrEn, busy, done, illegal;
  logic [IDX_W-1:0] rdAddr, wrAddr;
  logic [DATA_W-1:0] rdData, wrData, result;
  logic [3:0] crOut;

  logic [DATA_W-1:0] mem [MAX_VL];
  logic [DATA_W-1:0] snap [MAX_VL];
  logic [MAX_VL-1:0] curAct = '0;
  int checks = 0, errors = 0, memWrites = 0, maskedReads = 0;

  always #2.5 clk = ~clk;

  mask_reduce_unit #(.MAX_VL(MAX_VL), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen), .predMask(predMask),
    .opSel(opSel), .rcEn(rcEn), .crAll(crAll), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .busy(busy),
    .done(done), .illegal(illegal), .result(result), .crOut(crOut)
  );

  assign rdData = mem[rdAddr];

  always @(negedge clk) begin
    if (wrEn) begin
      mem[wrAddr] <= wrData;
      memWrites <= memWrites + 1;
    end
    if (rdEn && !curAct[rdAddr]) maskedReads <= maskedReads + 1;
  end

  task automatic chk(input string tag, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] refOp(input logic [2:0] op,
      input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    case (op)
      3'd1: return a * b;
      3'd2: return ($signed(b) < $signed(a)) ? b : a;
      3'd3: return ($signed(b) > $signed(a)) ? b : a;
      3'd4: return a | b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [3:0] refCr(input logic [DATA_W-1:0] v);
    return {v[DATA_W-1], !v[DATA_W-1] && v != 0, v == 0, 1'b0};
  endfunction

  task automatic fillMem(input int base, input int stride);
    for (int i = 0; i < MAX_VL; i++) mem[i] = DATA_W'(base + stride * i);
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk(tag, "done seen", {31'b0, done}, 32'd1);
  endtask

  // Run one reduction; 'disturb' pulses a second start mid-scan (R10)
  task automatic runCase(input string tag, input int vl, input logic [MAX_VL-1:0] mask,
      input logic [2:0] op, input bit rc, input bit all, input bit disturb);
    logic [DATA_W-1:0] expRes = '0;
    logic [3:0] cr = '0;
    int cnt = 0, dst = 0, lim;
    lim = (vl > MAX_VL) ? MAX_VL : vl;
    curAct = '0;
    for (int i = 0; i < MAX_VL; i++) snap[i] = mem[i];
    for (int i = 0; i < lim; i++) begin
      if (mask[i]) begin
        curAct[i] = 1'b1;
        if (cnt == 0) begin expRes = mem[i]; dst = i; end
        else begin
          expRes = refOp(op, expRes, mem[i]);
          if (cnt == 1) cr = refCr(expRes);
          else cr = all ? (cr & refCr(expRes)) : (cr | refCr(expRes));
        end
        cnt++;
      end
    end
    if (!(rc && cnt >= 2)) cr = '0;
    memWrites = 0; maskedReads = 0;
    @(negedge clk);
    vecLen = LEN_W'(vl); predMask = mask; opSel = op; rcEn = rc; crAll = all;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (2) @(negedge clk);
      opSel = 3'd4; predMask = 16'h00F0; vecLen = 5'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitDone(tag);
    chk(tag, "result", result, expRes);
    chk(tag, "crOut", {28'b0, crOut}, {28'b0, cr});
    @(negedge clk);
    chk(tag, "done pulse ends (R11)", {31'b0, done}, 32'd0);
    chk(tag, "result held (R11)", result, expRes);
    chk(tag, "write count (R4)", memWrites, (cnt > 0) ? 1 : 0);
    chk(tag, "masked reads (R3)", maskedReads, 0);
    if (cnt > 0) chk(tag, "destination value (R4)", mem[dst], expRes);
    begin
      int bad = 0;
      for (int i = 0; i < MAX_VL; i++) if (!curAct[i] && mem[i] !== snap[i]) bad++;
      chk(tag, "inactive elements untouched (R3)", bad, 0);
    end
  endtask

  task automatic testReset();
    chk("R1", "busy", {31'b0, busy}, 0);
    chk("R1", "done/illegal/rd/wr", {28'b0, done, illegal, rdEn, wrEn}, 0);
    chk("R1", "result", result, 0);
    chk("R1", "crOut", {28'b0, crOut}, 0);
  endtask

  task automatic testIllegal(input logic [2:0] op);
    memWrites = 0; maskedReads = 0; curAct = '0;
    @(negedge clk);
    vecLen = 5'd8; predMask = 16'hFFFF; opSel = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "illegal raised", {31'b0, illegal}, 1);
    chk("R9", "no done", {31'b0, done}, 0);
    @(negedge clk);
    chk("R9", "illegal pulse ends", {31'b0, illegal}, 0);
    chk("R9", "idle again", {31'b0, busy}, 0);
    chk("R9", "no write/read", memWrites + maskedReads, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    fillMem(1, 1);
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    // R2 add over full vector
    fillMem(10, 3);
    runCase("R2 add", 16, 16'hFFFF, 3'd0, 0, 0, 0);
    // R2 R3 multiply with sparse mask
    fillMem(2, 1);
    runCase("R2 R3 mul", 12, 16'hA5A5, 3'd1, 0, 0, 0);
    // R2 signed min and max across negatives
    fillMem(-20, 5);
    runCase("R2 min", 9, 16'h01FE, 3'd2, 0, 0, 0);
    runCase("R2 max", 16, 16'h7777, 3'd3, 0, 0, 0);
    fillMem(32'h11, 32'h30);
    runCase("R2 or", 10, 16'h03C3, 3'd4, 0, 0, 0);
    // R3 length clamp above MAX_VL
    fillMem(7, 2);
    runCase("R3 clamp", 20, 16'hFFFF, 3'd0, 0, 0, 0);
    // R6 R7 condition merging, partial sums cross zero
    fillMem(-6, 2);
    runCase("R6 R7 any", 8, 16'h00FF, 3'd0, 1, 0, 0);
    runCase("R6 R7 all", 8, 16'h00FF, 3'd0, 1, 1, 0);
    fillMem(1, 1);
    runCase("R7 all positive", 6, 16'h003F, 3'd0, 1, 1, 0);
    // R8 rc off
    fillMem(-6, 2);
    runCase("R8 rc off", 8, 16'h00FF, 3'd0, 0, 1, 0);
    // R5 single and empty
    fillMem(40, 1);
    runCase("R5 single", 16, 16'h0400, 3'd1, 1, 0, 0);
    runCase("R5 empty mask", 16, 16'h0000, 3'd0, 1, 0, 0);
    runCase("R5 zero length", 0, 16'hFFFF, 3'd0, 1, 0, 0);
    runCase("R5 R3 mask beyond length", 4, 16'hFFF0, 3'd0, 0, 0, 0);
    // R9 rejected codes
    testIllegal(3'd5);
    testIllegal(3'd6);
    testIllegal(3'd7);
    // R10 start while busy
    fillMem(3, 4);
    runCase("R10 busy start", 16, 16'hFFFF, 3'd0, 1, 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule